// File: doc/BRIEF.md
# Timer Channel Clock Gating Core

This block is the clock-control and counting core of one timer-counter channel. It gates an already selected counter tick into a free-running counter through two separate latches. The first is an enable latch that only an explicit enable command can set. The second is a run latch that triggers set and stop events clear. The counter advances only while both latches are set. Clock-source selection, capture storage, waveform output shaping and the register interface sit outside the block.

A single mode input picks capture or waveform operation, and each event source acts only in its own mode. In capture mode the second-capture load event can disable or stop the channel. In waveform mode the period-compare match can do either. Four configuration bits choose these actions. Four trigger sources (software, synchronous, external, compare) zero the counter and, when the channel is enabled, start it. A status output shows the enable latch.

The asynchronous active-low reset is released through a two-stage synchronizer. The first cycle that acts on inputs is therefore the third rising edge after `rst_ni` goes high.

Top module: `tmr_clk_gate_core`

## Requirements
- R1: After reset, `count_o` is 0 and `clk_enabled_o` is 0.
- R2: `cmd_en_i` sets `clk_enabled_o` at the next edge and `cmd_dis_i` clears it. When both arrive in one cycle, the result is disabled.
- R3: When `wave_mode_i`=0 and `cfg_dis_on_ldb_i`=1, a `ldb_evt_i` pulse clears the enable latch. With `wave_mode_i`=1, `ldb_evt_i` has no effect on either latch.
- R4: When `wave_mode_i`=1 and `cfg_dis_on_cmp_i`=1, a `cmp_evt_i` pulse clears the enable latch. With `wave_mode_i`=0, `cmp_evt_i` has no effect on either latch.
- R5: Any one of `trig_sw_i`, `trig_sync_i`, `trig_ext_i`, `trig_cmp_i` makes `count_o` 0 at the next edge, whatever the latch state. If the channel was enabled and is not being disabled in that cycle, it also sets the run latch.
- R6: While disabled, triggers and stop events leave the run latch unchanged. A trigger in the same cycle as an enable command does not start the channel. Clearing the enable latch also clears the run latch, so re-enabling needs a new trigger before counting resumes.
- R7: A stop event clears the run latch and leaves the enable latch set. In capture mode the stop event is `ldb_evt_i` with `cfg_stop_on_ldb_i`=1. In waveform mode it is `cmp_evt_i` with `cfg_stop_on_cmp_i`=1.
- R8: `count_o` rises by one on each cycle with `tick_i`=1 while enabled and running. It holds otherwise and wraps from all ones to 0.
- R9: A trigger and a stop event in the same cycle leave the channel running with `count_o` at 0. A disable in that cycle still wins over the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Selected counter clock tick, one cycle per count |
| cmd_en_i | input | 1 | Enable command pulse |
| cmd_dis_i | input | 1 | Disable command pulse |
| trig_sw_i | input | 1 | Software trigger |
| trig_sync_i | input | 1 | Synchronous (multi-channel) trigger |
| trig_ext_i | input | 1 | External trigger |
| trig_cmp_i | input | 1 | Compare trigger |
| wave_mode_i | input | 1 | 0 = capture mode, 1 = waveform mode |
| ldb_evt_i | input | 1 | Second-capture load event (capture mode) |
| cmp_evt_i | input | 1 | Period-compare match event (waveform mode) |
| cfg_dis_on_ldb_i | input | 1 | Load event disables the channel |
| cfg_dis_on_cmp_i | input | 1 | Compare event disables the channel |
| cfg_stop_on_ldb_i | input | 1 | Load event stops the channel |
| cfg_stop_on_cmp_i | input | 1 | Compare event stops the channel |
| count_o | output | CNT_W | Counter value |
| clk_enabled_o | output | 1 | High while the enable latch is set |

## Verification
A wrong enable latch shows on `clk_enabled_o` one edge after the offending command or event. The run latch has no port of its own, so a wrong run latch shows only through `count_o`. That happens on the first later `tick_i`: the counter either advances when it should hold or holds when it should advance. For that reason the bench keeps ticks flowing after every stop, disable and ignored-event case. A mode leak, where an event acts in the wrong mode, shows the same way within one or two cycles. The bench compares both outputs against a behavioural model on every clock and adds targeted value checks at the corner cases.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

  typedef enum logic {
    TCG_CAPTURE  = 1'b0,
    TCG_WAVEFORM = 1'b1
  } tcg_mode_e;

  typedef struct packed {
    logic dis_on_ldb;
    logic dis_on_cmp;
    logic stop_on_ldb;
    logic stop_on_cmp;
  } tcg_cfg_t;

  typedef struct packed {
    logic trig;
    logic dis;
    logic stop;
  } tcg_evt_t;

endpackage

// File: rtl/tcg_rst_sync.sv
module tcg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sh_q[STAGES-1];
endmodule

// File: rtl/tcg_evt_decode.sv
module tcg_evt_decode
  import tcg_pkg::*;
#(
  parameter int N_TRIG = 4
) (
  input  logic [N_TRIG-1:0] trig_vec_i,
  input  tcg_mode_e         mode_i,
  input  logic              ldb_evt_i,
  input  logic              cmp_evt_i,
  input  tcg_cfg_t          cfg_i,
  output tcg_evt_t          evt_o
);
  always_comb begin
    evt_o.trig = |trig_vec_i;
    evt_o.dis  = 1'b0;
    evt_o.stop = 1'b0;
    unique case (mode_i)
      TCG_CAPTURE: begin
        evt_o.dis  = ldb_evt_i & cfg_i.dis_on_ldb;
        evt_o.stop = ldb_evt_i & cfg_i.stop_on_ldb;
      end
      TCG_WAVEFORM: begin
        evt_o.dis  = cmp_evt_i & cfg_i.dis_on_cmp;
        evt_o.stop = cmp_evt_i & cfg_i.stop_on_cmp;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tcg_latch_ctl.sv
module tcg_latch_ctl
  import tcg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cmd_en_i,
  input  logic     cmd_dis_i,
  input  tcg_evt_t evt_i,
  output logic     en_o,
  output logic     run_o
);
  logic en_q, en_d, run_q, run_d;
  logic en_we, run_we;

  always_comb begin
    en_d  = en_q;
    en_we = 1'b0;
    if (cmd_dis_i || evt_i.dis) begin
      en_d  = 1'b0;
      en_we = 1'b1;
    end else if (cmd_en_i) begin
      en_d  = 1'b1;
      en_we = 1'b1;
    end
  end

  always_comb begin
    run_d  = run_q;
    run_we = 1'b0;
    if (!en_d) begin
      run_d  = 1'b0;
      run_we = 1'b1;
    end else if (en_q) begin
      if (evt_i.trig) begin
        run_d  = 1'b1;
        run_we = 1'b1;
      end else if (evt_i.stop) begin
        run_d  = 1'b0;
        run_we = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
    end else begin
      if (en_we)  en_q  <= en_d;
      if (run_we) run_q <= run_d;
    end
  end

  assign en_o  = en_q;
  assign run_o = run_q;

  p_dis_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_dis_i |=> !en_q);
  p_en_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_en_i && !cmd_dis_i && !evt_i.dis) |=> en_q);
  p_run_needs_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> en_q);
  p_disabled_no_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !run_q) |=> !run_q);
  p_trig_beats_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && evt_i.trig && !evt_i.dis && !cmd_dis_i) |=> run_q);
  p_stop_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.stop && !evt_i.trig) |=> !run_q);
endmodule

// File: rtl/tcg_counter.sv
module tcg_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_we;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_we = 1'b0;
    if (clr_i) begin
      cnt_d  = '0;
      cnt_we = 1'b1;
    end else if (adv_i) begin
      cnt_d  = cnt_q + ONE;
      cnt_we = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_trig_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  p_step_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && adv_i) |=> (cnt_q == $past(cnt_q) + ONE));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !adv_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_clk_gate_core.sv
module tmr_clk_gate_core
  import tcg_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RST_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cmd_en_i,
  input  logic             cmd_dis_i,
  input  logic             trig_sw_i,
  input  logic             trig_sync_i,
  input  logic             trig_ext_i,
  input  logic             trig_cmp_i,
  input  logic             wave_mode_i,
  input  logic             ldb_evt_i,
  input  logic             cmp_evt_i,
  input  logic             cfg_dis_on_ldb_i,
  input  logic             cfg_dis_on_cmp_i,
  input  logic             cfg_stop_on_ldb_i,
  input  logic             cfg_stop_on_cmp_i,
  output logic [CNT_W-1:0] count_o,
  output logic             clk_enabled_o
);
  localparam int N_TRIG = 4;

  logic              rst_n;
  logic [N_TRIG-1:0] trig_vec;
  tcg_cfg_t          cfg;
  tcg_mode_e         mode;
  tcg_evt_t          evt;
  logic              en, run;

  assign trig_vec = {trig_cmp_i, trig_ext_i, trig_sync_i, trig_sw_i};
  assign cfg      = '{dis_on_ldb: cfg_dis_on_ldb_i, dis_on_cmp: cfg_dis_on_cmp_i,
                      stop_on_ldb: cfg_stop_on_ldb_i, stop_on_cmp: cfg_stop_on_cmp_i};
  assign mode     = tcg_mode_e'(wave_mode_i);

  tcg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n));

  tcg_evt_decode #(.N_TRIG(N_TRIG)) u_dec (
    .trig_vec_i(trig_vec), .mode_i(mode), .ldb_evt_i(ldb_evt_i),
    .cmp_evt_i(cmp_evt_i), .cfg_i(cfg), .evt_o(evt));

  tcg_latch_ctl u_lat (
    .clk_i(clk_i), .rst_ni(rst_n), .cmd_en_i(cmd_en_i), .cmd_dis_i(cmd_dis_i),
    .evt_i(evt), .en_o(en), .run_o(run));

  tcg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .clr_i(evt.trig),
    .adv_i(tick_i & en & run), .cnt_o(count_o));

  assign clk_enabled_o = en;

  p_cap_ldb_dis_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!wave_mode_i && ldb_evt_i && cfg_dis_on_ldb_i) |=> !clk_enabled_o);
  p_wave_ldb_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wave_mode_i && !cmp_evt_i && !cmd_dis_i && !cmd_en_i && clk_enabled_o) |=> clk_enabled_o);
  p_wave_cmp_dis_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wave_mode_i && cmp_evt_i && cfg_dis_on_cmp_i) |=> !clk_enabled_o);
  p_cap_cmp_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!wave_mode_i && !ldb_evt_i && !cmd_dis_i && clk_enabled_o) |=> clk_enabled_o);
  p_reset_state_r1: assert property (@(posedge clk_i)
    !rst_n |-> (count_o == '0 && !clk_enabled_o));
endmodule

// File: tb/tb_tmr_clk_gate_core.sv
module tb_tmr_clk_gate_core;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni;
  logic tick, cen, cdis, tsw, tsy, tex, tcm, wave, ldb, cmp, cdl, cdc, csl, csc;
  logic [W-1:0] count;
  logic en_o;

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  tmr_clk_gate_core #(.CNT_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .cmd_en_i(cen), .cmd_dis_i(cdis),
    .trig_sw_i(tsw), .trig_sync_i(tsy), .trig_ext_i(tex), .trig_cmp_i(tcm),
    .wave_mode_i(wave), .ldb_evt_i(ldb), .cmp_evt_i(cmp),
    .cfg_dis_on_ldb_i(cdl), .cfg_dis_on_cmp_i(cdc),
    .cfg_stop_on_ldb_i(csl), .cfg_stop_on_cmp_i(csc),
    .count_o(count), .clk_enabled_o(en_o));

  // behavioural reference model
  bit m_en, m_run;
  int m_cnt;
  int rel;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = 0; m_run = 0; m_cnt = 0; rel = 0;
    end else if (rel < 2) begin
      rel++;
    end else begin
      bit cap, dev, sev, trg, n_en, n_run;
      cap  = !wave;
      dev  = cap ? (ldb && cdl) : (cmp && cdc);
      sev  = cap ? (ldb && csl) : (cmp && csc);
      trg  = tsw || tsy || tex || tcm;
      n_en = (cdis || dev) ? 1'b0 : (cen ? 1'b1 : m_en);
      if (!n_en)      n_run = 0;
      else if (!m_en) n_run = m_run;
      else if (trg)   n_run = 1;
      else if (sev)   n_run = 0;
      else            n_run = m_run;
      if (trg) m_cnt = 0;
      else if (m_en && m_run && tick) m_cnt = (m_cnt + 1) % (1 << W);
      m_en = n_en; m_run = n_run;
    end
  end

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  task automatic clr_pulses();
    cen = 0; cdis = 0; tsw = 0; tsy = 0; tex = 0; tcm = 0; ldb = 0; cmp = 0;
  endtask

  // one clock: wait edge, then compare against the model away from the edge
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk({tag, " count"}, int'(count), m_cnt);
      chk({tag, " status"}, int'(en_o), int'(m_en));
      clr_pulses();
    end
  endtask

  task automatic ticks(input int n);
    tick = 1; step(n); tick = 0;
  endtask

  bit done = 0;
  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clr_pulses();
    tick = 0; wave = 0; cdl = 0; cdc = 0; csl = 0; csc = 0;
    rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    step(3);
    tag = "R1"; chk("R1 reset count", int'(count), 0); chk("R1 reset status", int'(en_o), 0);
    ticks(3);
    chk("R1 ticks while disabled", int'(count), 0);

    tag = "R2"; cen = 1; step();
    chk("R2 enable sets status", int'(en_o), 1);
    cen = 1; cdis = 1; step();
    chk("R2 disable wins", int'(en_o), 0);

    tag = "R6"; tsw = 1; step(); cen = 1; step(); ticks(4);
    chk("R6 trigger while disabled ignored", int'(count), 0);
    cdis = 1; step(); cen = 1; tsw = 1; step(); ticks(3);
    chk("R6 trigger with enable ignored", int'(count), 0);

    tag = "R5"; tsw = 1; step(); ticks(5);
    chk("R5 sw trigger starts", int'(count), 5);
    tsy = 1; step(); chk("R5 sync trigger zeroes", int'(count), 0);
    ticks(2); tex = 1; step(); chk("R5 ext trigger zeroes", int'(count), 0);
    ticks(2); tcm = 1; step(); chk("R5 cmp trigger zeroes", int'(count), 0);
    ticks(2); chk("R5 running after cmp trigger", int'(count), 2);

    tag = "R8"; tsw = 1; step(); step(4); chk("R8 hold without tick", int'(count), 0);
    ticks(259); chk("R8 wrap", int'(count), 3);

    tag = "R7"; csl = 1; ldb = 1; step(); ticks(4);
    chk("R7 capture stop", int'(count), 3); chk("R7 still enabled", int'(en_o), 1);
    tsw = 1; step(); wave = 1; ldb = 1; step(); ticks(2);
    chk("R7 load ignored in waveform", int'(count), 2);
    csc = 1; cmp = 1; step(); ticks(3);
    chk("R7 waveform stop", int'(count), 2);

    tag = "R9"; tsw = 1; cmp = 1; step(); ticks(3);
    chk("R9 trigger beats stop", int'(count), 3);
    cdis = 1; tsw = 1; step(); chk("R9 disable beats trigger", int'(en_o), 0);
    csc = 0; csl = 0;

    tag = "R3"; cen = 1; step(); tsw = 1; step();
    wave = 1; cdl = 1; ldb = 1; step(); chk("R3 load ignored in waveform", int'(en_o), 1);
    ticks(2); chk("R3 still counting", int'(count), 2);
    wave = 0; ldb = 1; step(); chk("R3 capture load disables", int'(en_o), 0);
    cdl = 0;

    tag = "R4"; cen = 1; step(); tsw = 1; step();
    wave = 0; cdc = 1; cmp = 1; step(); chk("R4 compare ignored in capture", int'(en_o), 1);
    ticks(2); chk("R4 still counting", int'(count), 2);
    wave = 1; cmp = 1; step(); chk("R4 waveform compare disables", int'(en_o), 0);
    cdc = 0;

    tag = "R6"; cen = 1; step(); ticks(3);
    chk("R6 re-enable needs trigger", int'(count), 2);
    tsw = 1; step(); ticks(1); chk("R6 counts after trigger", int'(count), 1);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule